// File: doc/BRIEF.md
# VT1.5 Pointer Tracker

This block follows the payload pointer of one low-order virtual tributary. Once per four-frame multiframe an upstream extractor gives it the two pointer bytes of the selected tributary together with a one-cycle strobe. From each pair the block does the following:

- It pulls out the 10-bit offset, the new-data field and the size bits.
- It decides whether the pair confirms the current offset, signals a single justification step, forces a new offset, carries an alarm-indication pattern, or is invalid.

The block keeps the accepted offset for the downstream payload extractor. It reports loss of pointer, tributary AIS, a one-cycle new-data pulse and a size-bit mismatch flag. It also counts positive and negative justifications in two saturating counters.

All outputs are registered. They change only on the clock edge that samples a strobe, and they hold between strobes.

Top module: `vtp_tracker`

## Requirements
- R1: The fields come from fixed bit positions. The offset is {V1[1:0], V2[7:0]}, the new-data field is V1[7:4] and the size field is V1[3:2]. Outputs change only on the edge that samples `ptr_valid`. With no strobe every output holds, and `ndf` is low.
- R2: After reset `lop` is 1, `ptr_value` is 0, and `vt_ais`, `ndf`, `ss_mismatch` and both counters are 0.
- R3: An offset in the range 0..103 that arrives identically on 3 consecutive strobes becomes `ptr_value`, and this clears `lop` and `vt_ais`. `ptr_value` never exceeds 103.
- R4: The new-data field counts as set when it agrees with 1001 in at least 3 of its 4 bits. A set field with an in-range offset is adopted at once, and `ndf` pulses for one cycle. When the field agrees in 2 bits or fewer, it is ignored.
- R5: A positive justification applies while tracking (`lop` and `vt_ais` both low) and with the new-data field not set. It is recognised when at least 3 of the increment bits (offset bits 9,7,5,3,1) are inverted against `ptr_value` and fewer than 3 of the decrement bits are inverted. It adds 1 to `ptr_value`, wrapping 103 to 0, and adds 1 to `inc_count`.
- R6: A negative justification applies under the same conditions. It is recognised when at least 3 of the decrement bits (offset bits 8,6,4,2,0) are inverted and fewer than 3 of the increment bits are inverted. It subtracts 1 from `ptr_value`, wrapping 0 to 103, and adds 1 to `dec_count`.
- R7: Each justification counter steps by at most 1 per strobe and saturates at 2^CNT_W-1.
- R8: Each of the following counts as an invalid strobe: an out-of-range offset, or an offset that is neither confirmed nor a justification. On 8 consecutive invalid strobes, `lop` rises and `vt_ais` falls, and `ptr_value` keeps its last value.
- R9: A strobe with V1 and V2 both 0xFF is an alarm-indication strobe. On 3 consecutive such strobes, `vt_ais` rises and `lop` falls. These strobes reset the invalid-strobe run.
- R10: `ss_mismatch` is 1 exactly when the size field of the latest strobe differs from 11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ptr_valid | input | 1 | Strobe: V1/V2 bytes valid this cycle |
| v1_byte | input | 8 | First pointer byte |
| v2_byte | input | 8 | Second pointer byte |
| ptr_value | output | 10 | Accepted payload offset |
| lop | output | 1 | Loss of pointer |
| vt_ais | output | 1 | Tributary alarm indication |
| ndf | output | 1 | New-data pulse, one cycle |
| ss_mismatch | output | 1 | Size bits differ from 11 |
| inc_count | output | CNT_W | Saturating positive-justification count |
| dec_count | output | CNT_W | Saturating negative-justification count |

## Verification
The assertions check the following on every cycle:
- the offset stays in range;
- loss of pointer and AIS never hold together;
- outputs stay quiet without a strobe, and the new-data pulse only follows a strobe;
- each counter moves by single steps, and never both in the same cycle.

Only the bench scenarios can show the rest:
- whether a given byte pair is classified correctly: the three-strobe confirmation, the new-data majority vote, the I/D-bit majority and the wrap at 103;
- the exact strobe on which loss of pointer and AIS are declared;
- counter saturation.

// File: rtl/vtp_pkg.sv
package vtp_pkg;
    localparam int         PTR_W   = 10;
    localparam logic [9:0] INC_MSK = 10'h2AA;  // bits 9,7,5,3,1
    localparam logic [9:0] DEC_MSK = 10'h155;  // bits 8,6,4,2,0
    localparam logic [3:0] NDF_SET = 4'b1001;
    localparam logic [1:0] SS_EXP  = 2'b11;

    typedef struct packed {
        logic [3:0]       nd_field;
        logic [1:0]       ss_field;
        logic [PTR_W-1:0] offset;
    } ptr_word_t;
endpackage

// File: rtl/vtp_field_decode.sv
module vtp_field_decode
    import vtp_pkg::*;
#(
    parameter int MAX_PTR = 103
) (
    input  logic [7:0]       v1_byte,
    input  logic [7:0]       v2_byte,
    input  logic [PTR_W-1:0] cur_ptr,
    output ptr_word_t        word,
    output logic             is_ais,
    output logic             nd_set,
    output logic             in_range,
    output logic             inc_hit,
    output logic             dec_hit
);
    int i_flips;
    int d_flips;

    always_comb begin
        word     = ptr_word_t'({v1_byte, v2_byte});
        is_ais   = (v1_byte == 8'hFF) && (v2_byte == 8'hFF);
        nd_set   = $countones(~(word.nd_field ^ NDF_SET)) >= 3;
        in_range = word.offset <= PTR_W'(MAX_PTR);
        i_flips  = $countones((word.offset ^ cur_ptr) & INC_MSK);
        d_flips  = $countones((word.offset ^ cur_ptr) & DEC_MSK);
        inc_hit  = (i_flips >= 3) && (d_flips < 3);
        dec_hit  = (d_flips >= 3) && (i_flips < 3);
    end
endmodule

// File: rtl/vtp_sat_counter.sv
module vtp_sat_counter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         bump,
    output logic [W-1:0] count
);
    logic [W-1:0] count_d, count_q;

    always_comb begin
        count_d = count_q;
        if (bump && (count_q != '1)) count_d = count_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) count_q <= '0;
        else        count_q <= count_d;
    end

    assign count = count_q;
endmodule

// File: rtl/vtp_tracker.sv
module vtp_tracker
    import vtp_pkg::*;
#(
    parameter int CNT_W        = 8,
    parameter int MAX_PTR      = 103,
    parameter int ACCEPT_LIMIT = 3,
    parameter int AIS_LIMIT    = 3,
    parameter int INV_LIMIT    = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ptr_valid,
    input  logic [7:0]       v1_byte,
    input  logic [7:0]       v2_byte,
    output logic [9:0]       ptr_value,
    output logic             lop,
    output logic             vt_ais,
    output logic             ndf,
    output logic             ss_mismatch,
    output logic [CNT_W-1:0] inc_count,
    output logic [CNT_W-1:0] dec_count
);
    localparam int CAND_W = $clog2(ACCEPT_LIMIT + 1);
    localparam int AIS_W  = $clog2(AIS_LIMIT + 1);
    localparam int INV_W  = $clog2(INV_LIMIT + 1);

    typedef struct packed {
        logic [PTR_W-1:0] ptr;
        logic             lop;
        logic             ais;
        logic             ndf;
        logic             ss_bad;
        logic [PTR_W-1:0] cand;
        logic [CAND_W-1:0] cand_run;
        logic [AIS_W-1:0]  ais_run;
        logic [INV_W-1:0]  inv_run;
    } trk_t;

    trk_t      s_d, s_q;
    ptr_word_t word;
    logic      is_ais, nd_set, in_range, inc_hit, dec_hit;
    logic      tracking, bump_inc, bump_dec;

    vtp_field_decode #(.MAX_PTR(MAX_PTR)) u_dec (
        .v1_byte (v1_byte),
        .v2_byte (v2_byte),
        .cur_ptr (s_q.ptr),
        .word    (word),
        .is_ais  (is_ais),
        .nd_set  (nd_set),
        .in_range(in_range),
        .inc_hit (inc_hit),
        .dec_hit (dec_hit)
    );

    always_comb begin
        s_d      = s_q;
        s_d.ndf  = 1'b0;
        bump_inc = 1'b0;
        bump_dec = 1'b0;
        tracking = !s_q.lop && !s_q.ais;
        if (ptr_valid) begin
            s_d.ss_bad = (word.ss_field != SS_EXP);
            if (is_ais) begin
                s_d.cand_run = '0;
                s_d.inv_run  = '0;
                if (s_q.ais_run != AIS_W'(AIS_LIMIT)) s_d.ais_run = s_q.ais_run + 1'b1;
                if (s_d.ais_run == AIS_W'(AIS_LIMIT)) begin
                    s_d.ais = 1'b1;
                    s_d.lop = 1'b0;
                end
            end else begin
                s_d.ais_run = '0;
                if (nd_set && in_range) begin
                    s_d.ptr      = word.offset;
                    s_d.ndf      = 1'b1;
                    s_d.ais      = 1'b0;
                    s_d.lop      = 1'b0;
                    s_d.inv_run  = '0;
                    s_d.cand_run = '0;
                end else if (tracking && !nd_set && inc_hit) begin
                    s_d.ptr      = (s_q.ptr == PTR_W'(MAX_PTR)) ? '0 : s_q.ptr + 1'b1;
                    s_d.inv_run  = '0;
                    s_d.cand_run = '0;
                    bump_inc     = 1'b1;
                end else if (tracking && !nd_set && dec_hit) begin
                    s_d.ptr      = (s_q.ptr == '0) ? PTR_W'(MAX_PTR) : s_q.ptr - 1'b1;
                    s_d.inv_run  = '0;
                    s_d.cand_run = '0;
                    bump_dec     = 1'b1;
                end else if (tracking && in_range && (word.offset == s_q.ptr)) begin
                    s_d.inv_run  = '0;
                    s_d.cand_run = '0;
                end else begin
                    if (!in_range) begin
                        s_d.cand_run = '0;
                    end else if ((s_q.cand_run != '0) && (word.offset == s_q.cand)) begin
                        s_d.cand_run = s_q.cand_run + 1'b1;
                    end else begin
                        s_d.cand     = word.offset;
                        s_d.cand_run = CAND_W'(1);
                    end
                    if (in_range && (s_d.cand_run == CAND_W'(ACCEPT_LIMIT))) begin
                        s_d.ptr      = word.offset;
                        s_d.lop      = 1'b0;
                        s_d.ais      = 1'b0;
                        s_d.inv_run  = '0;
                        s_d.cand_run = '0;
                    end else begin
                        if (s_q.inv_run != INV_W'(INV_LIMIT)) s_d.inv_run = s_q.inv_run + 1'b1;
                        if (s_d.inv_run == INV_W'(INV_LIMIT)) begin
                            s_d.lop = 1'b1;
                            s_d.ais = 1'b0;
                        end
                    end
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q     <= '0;
            s_q.lop <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end

    genvar g;
    generate
        for (g = 0; g < 2; g++) begin : g_just
            logic [CNT_W-1:0] cnt;
            vtp_sat_counter #(.W(CNT_W)) u_cnt (
                .clk  (clk),
                .rst_n(rst_n),
                .bump ((g == 0) ? bump_inc : bump_dec),
                .count(cnt)
            );
        end
    endgenerate

    assign ptr_value   = s_q.ptr;
    assign lop         = s_q.lop;
    assign vt_ais      = s_q.ais;
    assign ndf         = s_q.ndf;
    assign ss_mismatch = s_q.ss_bad;
    assign inc_count   = g_just[0].cnt;
    assign dec_count   = g_just[1].cnt;
endmodule

// File: rtl/vtp_tracker_chk.sv
module vtp_tracker_chk #(
    parameter int CNT_W   = 8,
    parameter int MAX_PTR = 103
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ptr_valid,
    input logic [9:0]       ptr_value,
    input logic             lop,
    input logic             vt_ais,
    input logic             ndf,
    input logic [CNT_W-1:0] inc_count,
    input logic [CNT_W-1:0] dec_count
);
    AST_PTR_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        ptr_value <= 10'(MAX_PTR)); // R3

    AST_LOP_AIS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(lop && vt_ais)); // R8

    AST_NDF_AFTER_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        !ptr_valid |=> !ndf); // R4

    AST_QUIET_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !ptr_valid |=> $stable(ptr_value) && $stable(lop) && $stable(vt_ais)
                       && $stable(inc_count) && $stable(dec_count)); // R1

    AST_INC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (inc_count == $past(inc_count)) || (inc_count == $past(inc_count) + 1'b1)); // R7

    AST_DEC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (dec_count == $past(dec_count)) || (dec_count == $past(dec_count) + 1'b1)); // R7

    AST_JUST_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        (inc_count != $past(inc_count)) |-> (dec_count == $past(dec_count))); // R5
endmodule

bind vtp_tracker vtp_tracker_chk #(.CNT_W(CNT_W), .MAX_PTR(MAX_PTR)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .ptr_valid(ptr_valid),
    .ptr_value(ptr_value),
    .lop      (lop),
    .vt_ais   (vt_ais),
    .ndf      (ndf),
    .inc_count(inc_count),
    .dec_count(dec_count)
);

// File: tb/test_vtp_tracker.sv
module test_vtp_tracker;
    localparam int CNT_W = 3;
    localparam int NV    = 20;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             ptr_valid = 1'b0;
    logic [7:0]       v1_byte = 8'h00;
    logic [7:0]       v2_byte = 8'h00;
    logic [9:0]       ptr_value;
    logic             lop, vt_ais, ndf, ss_mismatch;
    logic [CNT_W-1:0] inc_count, dec_count;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    vtp_tracker #(.CNT_W(CNT_W)) i_vtp_tracker (
        .clk        (clk),
        .rst_n      (rst_n),
        .ptr_valid  (ptr_valid),
        .v1_byte    (v1_byte),
        .v2_byte    (v2_byte),
        .ptr_value  (ptr_value),
        .lop        (lop),
        .vt_ais     (vt_ais),
        .ndf        (ndf),
        .ss_mismatch(ss_mismatch),
        .inc_count  (inc_count),
        .dec_count  (dec_count)
    );

    // {v1, v2, ptr, lop, ais, ndf, inc, dec, ss}
    localparam logic [45:0] VEC [NV] = '{
        {8'h6C, 8'h32, 10'd0,   1'b1, 1'b0, 1'b0, 8'd0, 8'd0, 1'b0}, // R3 first sighting
        {8'h6C, 8'h32, 10'd0,   1'b1, 1'b0, 1'b0, 8'd0, 8'd0, 1'b0},
        {8'h6C, 8'h32, 10'd50,  1'b0, 1'b0, 1'b0, 8'd0, 8'd0, 1'b0}, // R3 third -> accept
        {8'h6C, 8'h32, 10'd50,  1'b0, 1'b0, 1'b0, 8'd0, 8'd0, 1'b0},
        {8'h6E, 8'h98, 10'd51,  1'b0, 1'b0, 1'b0, 8'd1, 8'd0, 1'b0}, // R5 I bits inverted
        {8'h6C, 8'h33, 10'd51,  1'b0, 1'b0, 1'b0, 8'd1, 8'd0, 1'b0},
        {8'h6D, 8'h66, 10'd50,  1'b0, 1'b0, 1'b0, 8'd1, 8'd1, 1'b0}, // R6 D bits inverted
        {8'h68, 8'h32, 10'd50,  1'b0, 1'b0, 1'b0, 8'd1, 8'd1, 1'b1}, // R10 size 10
        {8'h9C, 8'h64, 10'd100, 1'b0, 1'b0, 1'b1, 8'd1, 8'd1, 1'b0}, // R4 exact 1001
        {8'hBC, 8'h14, 10'd20,  1'b0, 1'b0, 1'b1, 8'd1, 8'd1, 1'b0}, // R4 1011, 3 agree
        {8'h6C, 8'h14, 10'd20,  1'b0, 1'b0, 1'b0, 8'd1, 8'd1, 1'b0},
        {8'h9C, 8'h67, 10'd103, 1'b0, 1'b0, 1'b1, 8'd1, 8'd1, 1'b0},
        {8'h6E, 8'hCD, 10'd0,   1'b0, 1'b0, 1'b0, 8'd2, 8'd1, 1'b0}, // R5 wrap 103->0
        {8'h6D, 8'h55, 10'd103, 1'b0, 1'b0, 1'b0, 8'd2, 8'd2, 1'b0}, // R6 wrap 0->103
        {8'hFF, 8'hFF, 10'd103, 1'b0, 1'b0, 1'b0, 8'd2, 8'd2, 1'b0}, // R9
        {8'hFF, 8'hFF, 10'd103, 1'b0, 1'b0, 1'b0, 8'd2, 8'd2, 1'b0},
        {8'hFF, 8'hFF, 10'd103, 1'b0, 1'b1, 1'b0, 8'd2, 8'd2, 1'b0}, // R9 third -> AIS
        {8'h6C, 8'h67, 10'd103, 1'b0, 1'b1, 1'b0, 8'd2, 8'd2, 1'b0},
        {8'h6C, 8'h67, 10'd103, 1'b0, 1'b1, 1'b0, 8'd2, 8'd2, 1'b0},
        {8'h6C, 8'h67, 10'd103, 1'b0, 1'b0, 1'b0, 8'd2, 8'd2, 1'b0}  // R3 clears AIS
    };

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic strobe(input logic [7:0] a, input logic [7:0] b);
        @(negedge clk);
        ptr_valid = 1'b1;
        v1_byte   = a;
        v2_byte   = b;
        @(negedge clk);
        ptr_valid = 1'b0;
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual running expected finished");
            finish_run();
        end
    end

    initial begin
        int cur;
        logic [9:0] rx;

        repeat (3) @(negedge clk);
        // R2 reset state
        check("R2", "lop", lop, 1);
        check("R2", "ptr", ptr_value, 0);
        check("R2", "ais", vt_ais, 0);
        check("R2", "ndf", ndf, 0);
        check("R2", "ss", ss_mismatch, 0);
        check("R2", "inc", inc_count, 0);
        check("R2", "dec", dec_count, 0);
        rst_n = 1'b1;

        for (int k = 0; k < NV; k++) begin
            strobe(VEC[k][45:38], VEC[k][37:30]);
            check("R3", "ptr", ptr_value, int'(VEC[k][29:20]));
            check("R8", "lop", lop, int'(VEC[k][19]));
            check("R9", "ais", vt_ais, int'(VEC[k][18]));
            check("R4", "ndf", ndf, int'(VEC[k][17]));
            check("R5", "inc", inc_count, int'(VEC[k][16:9]));
            check("R6", "dec", dec_count, int'(VEC[k][8:1]));
            check("R10", "ss", ss_mismatch, int'(VEC[k][0]));
        end

        // R1 hold with no strobe, even if bytes change
        v1_byte = 8'h9C;
        v2_byte = 8'h05;
        repeat (4) @(negedge clk);
        check("R1", "ptr hold", ptr_value, 103);
        check("R1", "ndf quiet", ndf, 0);

        // R4 new-data field 1111 agrees in 2 bits: ignored, offset 103 confirms
        strobe(8'hFC, 8'h67);
        check("R4", "ndf 2-bit", ndf, 0);
        check("R4", "ptr 2-bit", ptr_value, 103);

        // R8 seven out-of-range strobes keep tracking, the eighth loses pointer
        for (int k = 0; k < 7; k++) strobe(8'h6C, 8'hFF);
        check("R8", "lop after 7", lop, 0);
        strobe(8'h6C, 8'hFF);
        check("R8", "lop after 8", lop, 1);
        check("R8", "ptr kept", ptr_value, 103);

        // R7 re-enter via new data at 10, then six increments saturate at 7
        strobe(8'h9C, 8'h0A);
        check("R4", "ndf reacquire", ptr_value, 10);
        cur = 10;
        for (int k = 0; k < 6; k++) begin
            rx = 10'(cur) ^ 10'h2AA;
            strobe({6'b011011, rx[9:8]}, rx[7:0]);
            cur = (cur == 103) ? 0 : cur + 1;
        end
        check("R7", "inc saturated", inc_count, 7);
        check("R5", "ptr after incs", ptr_value, 16);
        check("R7", "dec unchanged", dec_count, 2);

        done = 1'b1;
        finish_run();
    end
endmodule